// File: doc/BRIEF.md
# CSR Read-Modify-Write Unit

This block carries out the six control-and-status-register access operations (swap, bit-set and bit-clear, each in a register-operand form and an immediate form) against a small local register file. The file holds several scratch registers, a retired-instruction counter, a read-only view of that counter and a read-only identity word. An already decoded operation arrives with its CSR address, function code, destination and source register indices and the source register's value. In the same cycle the unit returns the old CSR value for the destination register, a writeback enable, read and write side-effect strobes and an illegal-operation flag. The CSR update lands on the next rising clock edge.

Which strobes fire depends on whether the destination index, the source index or the immediate is zero, and that same rule decides whether an access to a read-only address faults. A separate retire pulse advances the counter. An explicit write to the counter takes the place of that cycle's increment.

Top module: `csr_rmw_unit`

## Requirements
- R1: Function codes 3'b000 and 3'b100 are not CSR accesses. While op_valid is high with such a code, rd_strobe, wr_strobe, rd_we and illegal stay low and no CSR changes.
- R2: Code 3'b001 (swap) returns the old CSR value on rd_value with rd_we high when rd_idx is nonzero, and writes rs1_value into the CSR.
- R3: A swap (3'b001 or 3'b101) with rd_idx zero keeps rd_strobe and rd_we low and rd_value zero, but still writes and raises wr_strobe.
- R4: Codes 3'b010/3'b110 set and 3'b011/3'b111 clear each CSR bit whose operand bit is 1, leaving the other bits alone. Only writable bits change: the scratch registers sit at 12'h340 upward (four by default), the last of them has only bits 15:0 writable, and all bits of the others and of the counter are writable.
- R5: A set or clear whose rs1_idx field is zero (register x0, or immediate zero) reads the CSR with rd_strobe high, keeps wr_strobe low, changes nothing and raises no fault even on a read-only address.
- R6: A set or clear with a nonzero rs1_idx whose value is zero still raises wr_strobe and leaves the CSR value unchanged.
- R7: A swap with rs1 set to x0, whose value is zero, writes zero into the CSR.
- R8: An address whose bits 11:10 are 2'b11 is read-only: 12'hC02 mirrors the counter and 12'hF11 returns the identity word 32'h5A5A_0001. Any operation there that would write raises illegal, keeps both strobes and rd_we low and changes no state.
- R9: An access with a valid function code to an address that is not implemented raises illegal, keeps both strobes and rd_we low and changes no state.
- R10: The counter at 12'hB02 adds one on each clock edge where retire is high. A read in the same cycle returns the value from before that increment.
- R11: A write to 12'hB02 replaces that cycle's increment, so the next access reads exactly the written value.
- R12: After reset every scratch register and the counter read zero. Outputs follow the inputs within the same cycle, and a write is visible from the next cycle on.
- R13: The immediate forms (bit 2 of the function code set) use the 5-bit rs1_idx field, zero-extended, as the operand in place of rs1_value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A decoded operation is present this cycle |
| csr_addr | input | 12 | CSR address field |
| funct3 | input | 3 | Function code |
| rd_idx | input | 5 | Destination register index |
| rs1_idx | input | 5 | Source register index, or immediate value |
| rs1_value | input | XLEN | Source register contents |
| retire | input | 1 | One instruction retired this cycle |
| rd_value | output | XLEN | Old CSR value for the destination register |
| rd_we | output | 1 | Destination register writeback enable |
| rd_strobe | output | 1 | CSR read performed (read side effect) |
| wr_strobe | output | 1 | CSR write performed (write side effect) |
| illegal | output | 1 | Illegal-operation fault |

## Verification
Each operation kind is driven with a nonzero source register, with x0, and with a nonzero register holding zero. This shows that the strobe decisions follow the index fields rather than the operand value. Set and clear are tried with overlapping bit patterns on a fully writable register and on the partly writable one. This tells the bit arithmetic apart from the write mask. Read-only and unimplemented addresses are hit with zero and nonzero sources, which separates a legal probe from a fault. The counter is read and written in the same cycles as retire pulses, which shows whether a read returns the pre-increment value and whether a write replaces the increment or adds to it.

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit #(
  parameter int XLEN = 32,
  parameter int NSCRATCH = 4,
  parameter logic [11:0] SCR_BASE = 12'h340,
  parameter logic [11:0] CNT_ADDR = 12'hB02,
  parameter logic [11:0] CNT_VIEW_ADDR = 12'hC02,
  parameter logic [11:0] ID_ADDR = 12'hF11,
  parameter logic [XLEN-1:0] ID_VALUE = 'h5A5A_0001,
  parameter logic [XLEN-1:0] PART_MASK = 'h0000_FFFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [11:0]     csr_addr,
  input  logic [2:0]      funct3,
  input  logic [4:0]      rd_idx,
  input  logic [4:0]      rs1_idx,
  input  logic [XLEN-1:0] rs1_value,
  input  logic            retire,
  output logic [XLEN-1:0] rd_value,
  output logic            rd_we,
  output logic            rd_strobe,
  output logic            wr_strobe,
  output logic            illegal
);
  localparam int IW = (NSCRATCH > 1) ? $clog2(NSCRATCH) : 1;
  localparam logic [11:0] NS12 = 12'(NSCRATCH);

  logic [NSCRATCH-1:0][XLEN-1:0] scr;
  logic [XLEN-1:0] cnt;
  logic [XLEN-1:0] old_val, operand, wdata;
  logic hit;

  wire access  = op_valid && (funct3[1:0] != 2'b00);
  wire is_swap = (funct3[1:0] == 2'b01);
  wire is_set  = (funct3[1:0] == 2'b10);
  wire want_rd = is_swap ? (rd_idx != 5'd0) : 1'b1;
  wire want_wr = is_swap ? 1'b1 : (rs1_idx != 5'd0);
  wire ro_addr = (csr_addr[11:10] == 2'b11);

  wire [11:0] scr_off = csr_addr - SCR_BASE;
  wire scr_hit = (scr_off < NS12);
  wire [IW-1:0] scr_idx = scr_off[IW-1:0];

  assign operand = funct3[2] ? {{(XLEN-5){1'b0}}, rs1_idx} : rs1_value;

  always_comb begin
    hit = 1'b1;
    old_val = '0;
    if (scr_hit) old_val = scr[scr_idx];
    else if (csr_addr == CNT_ADDR || csr_addr == CNT_VIEW_ADDR) old_val = cnt;
    else if (csr_addr == ID_ADDR) old_val = ID_VALUE;
    else hit = 1'b0;
  end

  assign wdata = is_swap ? operand : (is_set ? (old_val | operand) : (old_val & ~operand));

  assign illegal   = access && (!hit || (want_wr && ro_addr));
  assign rd_strobe = access && !illegal && want_rd;
  assign wr_strobe = access && !illegal && want_wr;
  assign rd_we     = access && !illegal && (rd_idx != 5'd0);
  assign rd_value  = rd_strobe ? old_val : '0;

  wire cnt_wr = wr_strobe && (csr_addr == CNT_ADDR);

  for (genvar g = 0; g < NSCRATCH; g++) begin : g_scr
    localparam logic [XLEN-1:0] M = (g == NSCRATCH - 1) ? PART_MASK : {XLEN{1'b1}};
    logic [XLEN-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_strobe && scr_hit && scr_idx == IW'(g)) q <= (q & ~M) | (wdata & M);
    end
    assign scr[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt_wr) cnt <= wdata;
    else if (retire) cnt <= cnt + XLEN'(1);
  end

  assert_noaccess_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && funct3[1:0] == 2'b00) |-> (!rd_strobe && !wr_strobe && !illegal && !rd_we));

  assert_noread_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |-> (rd_value == '0));

  assert_zero_src_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && funct3[1] && rs1_idx == 5'd0) |-> !wr_strobe);

  assert_ro_never_written_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && csr_addr[11:10] == 2'b11) |-> !wr_strobe);

  assert_fault_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!rd_strobe && !wr_strobe && !rd_we));

  assert_scr_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |=> $stable(scr));

  assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !(wr_strobe && csr_addr == CNT_ADDR)) |=> (cnt == $past(cnt) + XLEN'(1)));

  assert_cnt_replace_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && csr_addr == CNT_ADDR) |=> (cnt == $past(wdata)));
endmodule

// File: tb/test_csr_rmw_unit.sv
module test_csr_rmw_unit;
  localparam int XLEN = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, retire = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [2:0] funct3 = '0;
  logic [4:0] rd_idx = '0, rs1_idx = '0;
  logic [XLEN-1:0] rs1_value = '0;
  logic [XLEN-1:0] rd_value;
  logic rd_we, rd_strobe, wr_strobe, illegal;

  always #4 clk = ~clk;

  csr_rmw_unit i_csr_rmw_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .csr_addr(csr_addr),
    .funct3(funct3), .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs1_value(rs1_value),
    .retire(retire), .rd_value(rd_value), .rd_we(rd_we), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .illegal(illegal));

  typedef struct {
    logic [XLEN-1:0] val;
    logic we, rs, ws, ill;
    string req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  logic [XLEN-1:0] m_scr [4];
  logic [XLEN-1:0] m_cnt;

  task automatic issue(input logic [2:0] f3, input logic [11:0] a, input logic [4:0] rd,
                       input logic [4:0] rs1, input logic [XLEN-1:0] v, input logic ret,
                       input string req);
    exp_t e;
    logic acc, swap, dord, dowr, hit, ill;
    logic [XLEN-1:0] opnd, old, nv, mask;
    @(posedge clk); #1;
    op_valid = 1'b1; funct3 = f3; csr_addr = a; rd_idx = rd; rs1_idx = rs1;
    rs1_value = v; retire = ret;
    acc  = (f3[1:0] != 2'b00);
    swap = (f3[1:0] == 2'b01);
    opnd = f3[2] ? XLEN'(rs1) : v;
    dord = swap ? (rd != 0) : 1'b1;
    dowr = swap ? 1'b1 : (rs1 != 0);
    hit = 1'b1; old = '0; mask = '1;
    if (a >= 12'h340 && a <= 12'h343) begin
      old = m_scr[a - 12'h340];
      if (a == 12'h343) mask = 32'h0000_FFFF;
    end
    else if (a == 12'hB02 || a == 12'hC02) old = m_cnt;
    else if (a == 12'hF11) old = 32'h5A5A_0001;
    else hit = 1'b0;
    ill = acc && (!hit || (dowr && a[11:10] == 2'b11));
    e.ill = ill;
    e.rs = acc && !ill && dord;
    e.ws = acc && !ill && dowr;
    e.we = acc && !ill && (rd != 0);
    e.val = e.rs ? old : '0;
    e.req = req;
    q.push_back(e);
    nv = swap ? opnd : (f3[1:0] == 2'b10 ? (old | opnd) : (old & ~opnd));
    if (e.ws && a >= 12'h340 && a <= 12'h343)
      m_scr[a - 12'h340] = (old & ~mask) | (nv & mask);
    if (e.ws && a == 12'hB02) m_cnt = nv;
    else if (ret) m_cnt = m_cnt + 1;
  endtask

  task automatic idle(input logic ret);
    @(posedge clk); #1;
    op_valid = 1'b0; retire = ret;
    if (ret) m_cnt = m_cnt + 1;
  endtask

  always @(negedge clk) begin
    if (rst_n && op_valid) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL %s: output with no expected item", "R12");
      end else begin
        e = q.pop_front();
        if (rd_value !== e.val || rd_we !== e.we || rd_strobe !== e.rs ||
            wr_strobe !== e.ws || illegal !== e.ill) begin
          errors++;
          $display("FAIL %s: got val=%h we=%b rs=%b ws=%b ill=%b expected val=%h we=%b rs=%b ws=%b ill=%b",
                   e.req, rd_value, rd_we, rd_strobe, wr_strobe, illegal,
                   e.val, e.we, e.rs, e.ws, e.ill);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_scr[i] = '0;
    m_cnt = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12 reset values
    issue(3'b010, 12'h340, 5'd5, 5'd0, 32'h0, 1'b0, "R12");
    issue(3'b010, 12'hB02, 5'd5, 5'd0, 32'h0, 1'b0, "R12");
    // R2 swap, R12 write visible next cycle
    issue(3'b001, 12'h340, 5'd3, 5'd7, 32'hDEAD_BEEF, 1'b0, "R2");
    issue(3'b010, 12'h340, 5'd3, 5'd0, 32'h0, 1'b0, "R12");
    // R3 swap with rd=x0
    issue(3'b001, 12'h341, 5'd0, 5'd8, 32'h1234_5678, 1'b0, "R3");
    issue(3'b101, 12'h342, 5'd0, 5'd9, 32'h0, 1'b0, "R3");
    issue(3'b010, 12'h341, 5'd4, 5'd0, 32'h0, 1'b0, "R3");
    // R4 set / clear
    issue(3'b010, 12'h340, 5'd3, 5'd2, 32'h0000_00F0, 1'b0, "R4");
    issue(3'b011, 12'h340, 5'd3, 5'd2, 32'hFFFF_0000, 1'b0, "R4");
    issue(3'b010, 12'h340, 5'd3, 5'd0, 32'h0, 1'b0, "R4");
    issue(3'b001, 12'h343, 5'd3, 5'd2, 32'hFFFF_FFFF, 1'b0, "R4");
    issue(3'b011, 12'h343, 5'd3, 5'd2, 32'hFFFF_00F0, 1'b0, "R4");
    issue(3'b010, 12'h343, 5'd3, 5'd0, 32'h0, 1'b0, "R4");
    // R5 zero source
    issue(3'b011, 12'h341, 5'd6, 5'd0, 32'h0, 1'b0, "R5");
    issue(3'b111, 12'h341, 5'd6, 5'd0, 32'h0, 1'b0, "R5");
    issue(3'b010, 12'h341, 5'd6, 5'd0, 32'h0, 1'b0, "R5");
    // R6 nonzero register holding zero
    issue(3'b010, 12'h341, 5'd6, 5'd9, 32'h0, 1'b0, "R6");
    issue(3'b010, 12'h341, 5'd6, 5'd0, 32'h0, 1'b0, "R6");
    // R7 swap from x0 writes zero
    issue(3'b001, 12'h341, 5'd6, 5'd0, 32'h0, 1'b0, "R7");
    issue(3'b010, 12'h341, 5'd6, 5'd0, 32'h0, 1'b0, "R7");
    // R13 immediate zero-extension
    issue(3'b101, 12'h342, 5'd1, 5'd31, 32'hFFFF_FFFF, 1'b0, "R13");
    issue(3'b110, 12'h342, 5'd1, 5'd0, 32'hFFFF_FFFF, 1'b0, "R13");
    issue(3'b111, 12'h342, 5'd1, 5'd5, 32'h0, 1'b0, "R13");
    issue(3'b010, 12'h342, 5'd1, 5'd0, 32'h0, 1'b0, "R13");
    // R8 read-only
    issue(3'b010, 12'hF11, 5'd2, 5'd0, 32'h0, 1'b0, "R8");
    issue(3'b001, 12'hF11, 5'd2, 5'd3, 32'h1, 1'b0, "R8");
    issue(3'b101, 12'hC02, 5'd0, 5'd0, 32'h0, 1'b0, "R8");
    issue(3'b110, 12'hC02, 5'd2, 5'd4, 32'h0, 1'b0, "R8");
    issue(3'b111, 12'hC02, 5'd2, 5'd0, 32'h0, 1'b0, "R8");
    // R9 unimplemented
    issue(3'b010, 12'h7C0, 5'd2, 5'd0, 32'h0, 1'b0, "R9");
    issue(3'b001, 12'h344, 5'd2, 5'd1, 32'h5, 1'b0, "R9");
    issue(3'b010, 12'h340, 5'd2, 5'd0, 32'h0, 1'b0, "R9");
    // R1 non-access codes
    issue(3'b000, 12'h340, 5'd2, 5'd1, 32'hFFFF_FFFF, 1'b0, "R1");
    issue(3'b100, 12'h340, 5'd2, 5'd1, 32'hFFFF_FFFF, 1'b0, "R1");
    issue(3'b010, 12'h340, 5'd2, 5'd0, 32'h0, 1'b0, "R1");
    // R10 counter
    idle(1'b1); idle(1'b1); idle(1'b1);
    issue(3'b010, 12'hB02, 5'd2, 5'd0, 32'h0, 1'b1, "R10");
    issue(3'b010, 12'hC02, 5'd2, 5'd0, 32'h0, 1'b1, "R10");
    issue(3'b010, 12'hB02, 5'd2, 5'd0, 32'h0, 1'b0, "R10");
    // R11 counter write replaces increment
    issue(3'b001, 12'hB02, 5'd2, 5'd3, 32'd100, 1'b1, "R11");
    issue(3'b010, 12'hB02, 5'd2, 5'd0, 32'h0, 1'b0, "R11");
    issue(3'b110, 12'hB02, 5'd2, 5'd3, 32'h0, 1'b1, "R11");
    issue(3'b010, 12'hC02, 5'd2, 5'd0, 32'h0, 1'b0, "R11");
    idle(1'b0);
    repeat (2) @(posedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R12: %0d expected items never produced, expected 0", q.size());
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R12: watchdog expired, got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule